// File: doc/BRIEF.md
# Signed-Count 40-bit Barrel Shifter

This block moves a 40-bit operand left or right by a signed amount in one clock. The operand is either a 40-bit accumulator value or a 16-bit data word widened to 40 bits. A positive count shifts left, and the bits it vacates at the bottom are zeros. A negative count shifts right. The bits vacated at the top are copies of the sign bit in arithmetic mode and zeros in logical mode.

The count is a 6-bit two's-complement value taken from one of three places, chosen by a select input: an instruction field, a count field of a status word, or the low bits of a temporary register. A count below -16 is limited to -16. The usable left range is 0 to 31 and the usable right range is 0 to 16.

An exponent encoder runs beside the shifter. It counts the redundant sign bits of the operand and reports that number minus eight. Shifting left by this exponent places the value with eight guard bits above bit 31. When the normalize input is set, the exponent replaces the selected count, so a value is normalized in a single pass. The shifted result and the exponent are both registered and appear one clock after the inputs.

Top module: `sign_shift40`

## Requirements
- R1: While rst_n is low, shift_out and exp_out are zero.
- R2: A count c from 0 to 31 gives shift_out = operand shifted left by c, with the low c bits zero and the bits above bit 39 discarded.
- R3: A negative count c with arith_mode=1 gives operand shifted right by -c, with the top -c bits copies of operand bit 39.
- R4: A negative count c with arith_mode=0 and normalize=0 gives operand shifted right by -c, with the top -c bits zero.
- R5: cnt_sel selects the count source: 0 selects instr_cnt, 1 selects stat_cnt, and 2 or 3 selects temp_reg[5:0]. Each count is read as 6-bit two's complement.
- R6: A selected count from -32 to -17 acts as -16.
- R7: With use_data=1, the operand is data_in[15:0] in bits 15:0. Bits 39:16 are copies of data_in[15] when arith_mode=1 and zero when arith_mode=0. With use_data=0, the operand is acc_in.
- R8: exp_out is a 6-bit two's-complement value equal to the number of operand bits directly below bit 39 that equal bit 39, minus 8. Its range is -8 to 31, and it is 31 for an operand of zero.
- R9: With normalize=1, the exponent is used as the count in place of cnt_sel, and a right shift is arithmetic. For an operand that is neither all zeros nor all ones, shift_out[31] then differs from shift_out[30].
- R10: Both outputs reflect the inputs present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_in | input | 40 | Accumulator operand |
| data_in | input | 16 | Data word operand |
| use_data | input | 1 | 1 selects data_in as the operand |
| arith_mode | input | 1 | 1 selects sign fill, 0 selects zero fill |
| normalize | input | 1 | 1 uses the exponent as the count |
| cnt_sel | input | 2 | Count source select |
| instr_cnt | input | 6 | Count from the instruction field |
| stat_cnt | input | 6 | Count from the status word |
| temp_reg | input | 16 | Temporary register; bits 5:0 serve as a count |
| shift_out | output | 40 | Registered shift result |
| exp_out | output | 6 | Registered exponent |

## Verification
The directed phases separate three groups of cases:
- Left shifts at counts 0, 1, 17 and 31, which expose errors in bit discard and zero fill.
- Right shifts of both positive and negative operands in each mode, which tell sign fill apart from zero fill.
- Counts of -16, -17 and -32, which tell the clamp apart from wrap-around.

Source-select runs give the unselected count fields values that would produce a different result, so a wrong mux choice shows at the output. Exponent and normalize runs cover zero, all ones, small positive and negative values, and values that use the guard bits, which forces right-shifting normalization. A long random run then compares every cycle against the behavioural model.

// File: rtl/sign_shift40.sv
module sign_shift40 #(
  parameter int W    = 40,
  parameter int DW   = 16,
  parameter int CW   = 6,
  parameter int LMAX = 31,
  parameter int RMAX = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  acc_in,
  input  logic [DW-1:0] data_in,
  input  logic          use_data,
  input  logic          arith_mode,
  input  logic          normalize,
  input  logic [1:0]    cnt_sel,
  input  logic [CW-1:0] instr_cnt,
  input  logic [CW-1:0] stat_cnt,
  input  logic [DW-1:0] temp_reg,
  output logic [W-1:0]  shift_out,
  output logic [CW-1:0] exp_out
);
  localparam int GUARD = W - 32;

  logic [W-1:0]  opnd;
  logic [CW-1:0] raw_cnt;
  logic [CW-1:0] exp_val;
  logic          arith;
  int            red;
  int            cnt;
  logic [W-1:0]  result;

  assign opnd    = use_data ? {{(W-DW){arith_mode & data_in[DW-1]}}, data_in} : acc_in;
  assign raw_cnt = (cnt_sel == 2'd0) ? instr_cnt :
                   (cnt_sel == 2'd1) ? stat_cnt  : temp_reg[CW-1:0];
  assign arith   = arith_mode | normalize;

  always_comb begin
    red = 0;
    for (int i = W - 2; i >= 0; i--)
      if (opnd[i] == opnd[W-1] && red == W - 2 - i) red = W - 1 - i;
  end

  assign exp_val = CW'(red - GUARD);

  always_comb begin
    cnt = normalize ? int'($signed(exp_val)) : int'($signed(raw_cnt));
    if (cnt < -RMAX) cnt = -RMAX;
    if (cnt > LMAX)  cnt = LMAX;
  end

  always_comb begin
    if (cnt >= 0)   result = opnd << cnt;
    else if (arith) result = W'($signed(opnd) >>> (-cnt));
    else            result = opnd >> (-cnt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_out <= '0;
      exp_out   <= '0;
    end else begin
      shift_out <= result;
      exp_out   <= exp_val;
    end
  end

  assert_zero_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!normalize && cnt_sel == 2'd0 && $signed(instr_cnt) > 0) |=> shift_out[0] == 1'b0);

  assert_sign_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_data && arith_mode && !normalize && cnt_sel == 2'd0 &&
     $signed(instr_cnt) < 0 && acc_in[W-1]) |=> shift_out[W-1]);

  assert_logic_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!arith_mode && !normalize && cnt_sel == 2'd0 && $signed(instr_cnt) < 0)
    |=> shift_out[W-1] == 1'b0);

  assert_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_data && !arith_mode && !normalize && cnt_sel == 2'd0 && instr_cnt == CW'(-32))
    |=> shift_out == ($past(acc_in) >> RMAX));

  assert_exp_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $signed(exp_out) >= -GUARD);

  assert_exp_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_data && acc_in == '0) |=> exp_out == CW'(W - 1 - GUARD));

  assert_norm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (normalize && !use_data && acc_in != '0 && acc_in != '1)
    |=> shift_out[31] != shift_out[30]);
endmodule

// File: tb/sign_shift40_tb_top.sv
module sign_shift40_tb_top;
  logic        clk = 0;
  logic        rst_n;
  logic [39:0] acc_in;
  logic [15:0] data_in;
  logic        use_data, arith_mode, normalize;
  logic [1:0]  cnt_sel;
  logic [5:0]  instr_cnt, stat_cnt;
  logic [15:0] temp_reg;
  logic [39:0] shift_out;
  logic [5:0]  exp_out;

  int    checks = 0;
  int    fails  = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  sign_shift40 dut_i (
    .clk(clk), .rst_n(rst_n), .acc_in(acc_in), .data_in(data_in),
    .use_data(use_data), .arith_mode(arith_mode), .normalize(normalize),
    .cnt_sel(cnt_sel), .instr_cnt(instr_cnt), .stat_cnt(stat_cnt),
    .temp_reg(temp_reg), .shift_out(shift_out), .exp_out(exp_out));

  function automatic logic [45:0] model();
    logic [39:0] op;
    logic [39:0] r;
    longint v;
    int red, e, c;
    op = use_data ? (arith_mode ? {{24{data_in[15]}}, data_in} : {24'b0, data_in}) : acc_in;
    red = 0;
    for (int i = 38; i >= 0; i--) begin
      if (op[i] != op[39]) break;
      red++;
    end
    e = red - 8;
    if (normalize) c = e;
    else case (cnt_sel)
      2'd0:    c = int'($signed(instr_cnt));
      2'd1:    c = int'($signed(stat_cnt));
      default: c = int'($signed(temp_reg[5:0]));
    endcase
    if (c < -16) c = -16;
    if (c > 31)  c = 31;
    if (c >= 0) r = op << c;
    else if (arith_mode || normalize) begin
      v = longint'($signed(op));
      v = v >>> (-c);
      r = v[39:0];
    end else r = op >> (-c);
    return {e[5:0], r};
  endfunction

  task automatic check(input logic [45:0] exp_v);
    checks++;
    if ({exp_out, shift_out} !== exp_v) begin
      fails++;
      $display("FAIL %s: exp_out=%0h shift_out=%h expected exp_out=%0h shift_out=%h",
               cur_req, exp_out, shift_out, exp_v[45:40], exp_v[39:0]);
    end
  endtask

  task automatic vec(input logic [39:0] a, input logic [15:0] d, input bit ud, input bit am,
                     input bit nm, input logic [1:0] sel, input logic [5:0] ic,
                     input logic [5:0] sc, input logic [15:0] tr);
    logic [45:0] e;
    acc_in = a; data_in = d; use_data = ud; arith_mode = am; normalize = nm;
    cnt_sel = sel; instr_cnt = ic; stat_cnt = sc; temp_reg = tr;
    e = model();
    @(negedge clk);
    check(e);
  endtask

  task automatic sh(input logic [39:0] a, input bit am, input int c);
    vec(a, 16'h0, 0, am, 0, 2'd0, 6'(c), 6'd0, 16'h0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0;
    acc_in = 40'hFF_FFFF_FFFF; data_in = 16'hFFFF; use_data = 0; arith_mode = 1;
    normalize = 0; cnt_sel = 0; instr_cnt = 6'd3; stat_cnt = 0; temp_reg = 0;
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check(46'h0);
    rst_n = 1;

    cur_req = "R2";
    sh(40'h12_3456_789A, 0, 0);
    sh(40'h12_3456_789A, 1, 1);
    sh(40'hFF_8000_0001, 1, 17);
    sh(40'h00_0000_00FF, 0, 31);
    sh(40'hA5_A5A5_A5A5, 1, 31);

    cur_req = "R3";
    sh(40'h80_0000_0000, 1, -1);
    sh(40'hC3_1234_5678, 1, -9);
    sh(40'h7F_FFFF_0000, 1, -16);

    cur_req = "R4";
    sh(40'h80_0000_0000, 0, -1);
    sh(40'hC3_1234_5678, 0, -9);
    sh(40'hFF_FFFF_FFFF, 0, -16);

    cur_req = "R5";
    vec(40'h00_0001_0000, 0, 0, 1, 0, 2'd1, 6'd20, 6'd5, 16'h0030);
    vec(40'h00_0001_0000, 0, 0, 1, 0, 2'd2, 6'd20, 6'd5, 16'hFFF3);
    vec(40'h00_0001_0000, 0, 0, 1, 0, 2'd3, 6'd20, 6'd5, 16'h0007);
    vec(40'h00_0001_0000, 0, 0, 1, 0, 2'd0, 6'd20, 6'd5, 16'h0007);

    cur_req = "R6";
    sh(40'hF0_0000_0000, 1, -16);
    sh(40'hF0_0000_0000, 1, -17);
    sh(40'hF0_0000_0000, 1, -32);
    sh(40'hF0_0000_0000, 0, -32);

    cur_req = "R7";
    vec(40'hFF_0000_0000, 16'h8001, 1, 1, 0, 2'd0, 6'd4, 0, 0);
    vec(40'hFF_0000_0000, 16'h8001, 1, 0, 0, 2'd0, 6'd4, 0, 0);
    vec(40'h0, 16'hF000, 1, 1, 0, 2'd0, -6'd4, 0, 0);
    vec(40'h0, 16'hF000, 1, 0, 0, 2'd0, -6'd4, 0, 0);

    cur_req = "R8";
    sh(40'h0, 0, 0);
    sh(40'hFF_FFFF_FFFF, 0, 0);
    sh(40'h40_0000_0000, 0, 0);
    sh(40'h00_8000_0000, 0, 0);
    sh(40'h00_0000_0001, 0, 0);

    cur_req = "R9";
    vec(40'h00_0000_0001, 0, 0, 0, 1, 2'd0, 6'd0, 0, 0);
    vec(40'h40_0000_0000, 0, 0, 0, 1, 2'd0, 6'd0, 0, 0);
    vec(40'hC0_0000_0000, 0, 0, 0, 1, 2'd1, 6'd0, 0, 0);
    vec(40'hFF_FFFF_FFF0, 0, 0, 0, 1, 2'd2, 6'd0, 0, 0);
    vec(40'h0, 16'h0003, 1, 0, 1, 2'd0, 6'd0, 0, 0);
    vec(40'h0, 0, 0, 0, 1, 2'd0, 6'd0, 0, 0);

    cur_req = "R10";
    for (int k = 0; k < 2000; k++)
      vec({$urandom, $urandom} >> ($urandom % 40), 16'($urandom), 1'($urandom % 4 == 0),
          1'($urandom), 1'($urandom % 5 == 0), 2'($urandom), 6'($urandom),
          6'($urandom), 16'($urandom));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule